// File: doc/BRIEF.md
# Two-wire serial slave front end

This block is the slave side of a two-wire serial memory port. It is clocked by a fast system clock and watches the bus clock (SCL) and bus data (SDA) through two-flop synchronizers. It recognises START and STOP conditions, shifts in an address byte and compares it with a fixed device type code and three select pins, and answers with an acknowledge by pulling SDA low. After an accepted address it either receives bytes from the master or sends bytes to it, most significant bit first.

A memory back-end sits behind the block. Each received write byte is handed over on `rx_data` with a one-cycle `wr_stb`. For reads the block latches `tx_data` at the start of each outgoing byte and pulses `rd_stb`, so the back-end can advance its address counter. A one-cycle `stop_stb` marks a STOP that ends an addressed transfer, which the back-end can use to launch its internal write cycle. While the back-end holds `busy_i` high, every address is refused, so a master can poll the device until the write cycle has finished.

The pad is modelled as an active-high pull-down enable `sda_oe` and a sampled input `sda_i`. The bus itself computes the wired-AND. The system clock must run at no less than eight times the SCL rate.

States: `ST_IDLE` (bus ignored), `ST_ADDR` (address byte shifting in), `ST_ADDR_ACK` (address acknowledge), `ST_WR_BYTE` / `ST_WR_ACK` (write byte and its acknowledge), `ST_RD_BYTE` / `ST_RD_ACK` (read byte and the master's acknowledge).

Transitions:
- A STOP from any state goes to `ST_IDLE`.
- A START from any state goes to `ST_ADDR`.
- In `ST_ADDR`, at the end of the eighth bit, the block goes to `ST_ADDR_ACK` on a hit and to `ST_IDLE` on a miss.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, following the direction bit.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`. From there the block goes back to `ST_RD_BYTE` if the master acknowledged, and to `ST_IDLE` if it did not.

Top module: `twsl_slave`

## Requirements
- R1: After reset `sda_oe`, `wr_stb`, `rd_stb` and `stop_stb` are low. The block responds only to an address byte that follows a START, where a START is SDA falling while SCL is high.
- R2: An address byte whose bits [7:4] equal 1010 and whose bits [3:1] equal `sel_i[2:0]` is acknowledged: `sda_oe` is high during the ninth SCL clock. Bit 0 selects the direction, with 1 meaning read.
- R3: An address byte with a wrong type code or wrong select bits gets no acknowledge. The block then drives nothing and strobes nothing until the next START.
- R4: In write direction each data byte is taken MSB first, acknowledged in the ninth clock, and presented on `rx_data` with exactly one single-cycle `wr_stb`.
- R5: In read direction each byte is `tx_data` sampled at the `rd_stb` pulse that starts it. The byte is sent MSB first, with a 0 bit pulling SDA low and a 1 bit leaving it released. `wr_stb` and `rd_stb` are never high together.
- R6: After a read byte the block releases SDA for the ninth clock. A master acknowledge (SDA low) starts the next byte. A missing acknowledge ends transmission: further SCL clocks read all ones and produce no `rd_stb`.
- R7: While `busy_i` is high at the end of an address byte, the address gets no acknowledge, whatever it contains.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle. It pulses `stop_stb` for one cycle only if a transfer was active; a STOP seen while idle produces no pulse.
- R9: A START in the middle of a byte abandons that byte without a strobe and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND result) |
| sda_oe | output | 1 | High to pull SDA low, low to release it |
| sel_i | input | 3 | Device select pins compared with address bits [3:1] |
| busy_i | input | 1 | Back-end write cycle in progress; addresses are refused |
| rx_data | output | 8 | Last received write byte |
| wr_stb | output | 1 | One-cycle pulse when `rx_data` holds a new byte |
| tx_data | input | 8 | Byte to transmit, sampled at `rd_stb` |
| rd_stb | output | 1 | One-cycle pulse when `tx_data` is taken for sending |
| stop_stb | output | 1 | One-cycle pulse on a STOP that ends an active transfer |

## Verification
An SCL or SDA edge at the pins passes through two synchronizer flops and one edge-compare register. The state, `sda_oe` and the strobes therefore change three system clocks after the bus edge. The bench holds every SCL phase for eight clocks and reads SDA on the last falling system-clock edge of the low phase, well after the slave's answer has settled. The strobes are counted on every clock by a monitor, and the counts and captured bytes are compared only after the whole byte, STOP or NACK has completed.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } state_t;

endpackage

// File: rtl/twsl_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines, with a
// one-cycle-delayed copy of each synchronized line for edge detection.
module twsl_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout,
    output logic [LINES-1:0] dprev
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe     <= '1;
                dprev[g] <= 1'b1;
            end else begin
                pipe     <= {pipe[STAGES-2:0], din[g]};
                dprev[g] <= pipe[STAGES-1];
            end
        end
        assign dout[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/twsl_cond.sv
// Bus condition decoder working on the synchronized line pair.
module twsl_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_held_high;

    assign scl_held_high = scl_now & scl_prev;
    assign start_det     = scl_held_high & sda_prev & ~sda_now;
    assign stop_det      = scl_held_high & ~sda_prev & sda_now;
    assign scl_rise      = scl_now & ~scl_prev;
    assign scl_fall      = ~scl_now & scl_prev;

endmodule

// File: rtl/twsl_shreg.sv
// Receive and transmit shift registers, both MSB first.
module twsl_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             sample_bit,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    output logic [WIDTH-1:0] rx_word,
    output logic             tx_bit
);

    logic [WIDTH-1:0] tx_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (sample_en) begin
            rx_word <= {rx_word[WIDTH-2:0], sample_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '1;
        end else if (load_en) begin
            tx_word <= load_val;
        end else if (shift_en) begin
            tx_word <= {tx_word[WIDTH-2:0], 1'b1};
        end
    end

    assign tx_bit = tx_word[WIDTH-1];

endmodule

// File: rtl/twsl_slave.sv
module twsl_slave #(
    parameter int                TYPE_W      = 4,
    parameter int                SEL_W       = 3,
    parameter logic [TYPE_W-1:0] TYPE_CODE   = 4'b1010,
    parameter int                SYNC_STAGES = 2,
    localparam int               DATA_W      = TYPE_W + SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] rx_data,
    output logic              wr_stb,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rd_stb,
    output logic              stop_stb
);
    import twsl_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    // synchronized bus lines: index 1 is SCL, index 0 is SDA
    logic [1:0] line_now;
    logic [1:0] line_prev;
    logic       scl_s, scl_q, sda_s, sda_q;
    logic       start_det, stop_det, scl_rise, scl_fall;

    state_t            state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q;
    logic              ack_q;
    logic [DATA_W-1:0] rx_word;
    logic              tx_bit;

    logic byte_done, last_out, addr_hit, bus_event;
    logic sample_en, enter_tx, shift_out, byte_in;

    twsl_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_now),
        .dprev (line_prev)
    );

    assign scl_s = line_now[1];
    assign sda_s = line_now[0];
    assign scl_q = line_prev[1];
    assign sda_q = line_prev[0];

    twsl_cond u_cond (
        .scl_now   (scl_s),
        .scl_prev  (scl_q),
        .sda_now   (sda_s),
        .sda_prev  (sda_q),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    assign bus_event = start_det | stop_det;
    assign byte_done = (bit_cnt == CNT_FULL);
    assign last_out  = (bit_cnt == CNT_LAST);
    assign addr_hit  = (rx_word[DATA_W-1 -: TYPE_W] == TYPE_CODE) &&
                       (rx_word[SEL_W:1] == sel_i) && !busy_i;

    assign sample_en = scl_rise && (state_q == ST_ADDR || state_q == ST_WR_BYTE);
    assign enter_tx  = scl_fall && !bus_event &&
                       ((state_q == ST_ADDR_ACK && rw_q) ||
                        (state_q == ST_RD_ACK   && ack_q));
    assign shift_out = scl_fall && !bus_event && state_q == ST_RD_BYTE && !last_out;
    assign byte_in   = scl_fall && !bus_event && state_q == ST_WR_BYTE && byte_done;

    twsl_shreg #(
        .WIDTH (DATA_W)
    ) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .sample_bit (sda_s),
        .load_en    (enter_tx),
        .load_val   (tx_data),
        .shift_en   (shift_out),
        .rx_word    (rx_word),
        .tx_bit     (tx_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR:
                    if (scl_fall && byte_done)
                        state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:
                    if (scl_fall)
                        state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (scl_fall && byte_done)
                        state_d = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall)
                        state_d = ST_WR_BYTE;
                ST_RD_BYTE:
                    if (scl_fall && last_out)
                        state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall)
                        state_d = ack_q ? ST_RD_BYTE : ST_IDLE;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit counter and transfer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rw_q    <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            if (start_det ||
                (scl_fall && (state_q == ST_ADDR_ACK ||
                              state_q == ST_WR_ACK   ||
                              state_q == ST_RD_ACK))) begin
                bit_cnt <= '0;
            end else if (sample_en) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && state_q == ST_RD_BYTE) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state_q == ST_ADDR && state_d == ST_ADDR_ACK) begin
                rw_q <= rx_word[0];
            end
            if (state_q == ST_RD_ACK && scl_rise) begin
                ack_q <= ~sda_s;
            end
        end
    end

    // back-end strobes and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            stop_stb <= 1'b0;
        end else begin
            wr_stb   <= byte_in;
            rd_stb   <= enter_tx;
            stop_stb <= stop_det && (state_q != ST_IDLE);
            if (byte_in) begin
                rx_data <= rx_word;
            end
        end
    end

    // pad control
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_bit;
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/twsl_slave_chk.sv
module twsl_slave_chk #(
    parameter int                TYPE_W    = 4,
    parameter int                SEL_W     = 3,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010,
    localparam int               DATA_W    = TYPE_W + SEL_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input twsl_pkg::state_t     state_q,
    input logic                 start_det,
    input logic                 stop_det,
    input logic                 busy_i,
    input logic [SEL_W-1:0]     sel_i,
    input logic [DATA_W-1:0]    rx_word,
    input logic                 wr_stb,
    input logic                 rd_stb,
    input logic                 stop_stb
);
    import twsl_pkg::*;

    p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |->
        ($past(rx_word[DATA_W-1 -: TYPE_W]) == TYPE_CODE &&
         $past(rx_word[SEL_W:1]) == $past(sel_i)));

    p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> !$past(busy_i));

    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    p_stop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> (state_q == ST_IDLE && $past(state_q) != ST_IDLE));

    p_restart_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == ST_ADDR));

endmodule

bind twsl_slave twsl_slave_chk #(
    .TYPE_W    (TYPE_W),
    .SEL_W     (SEL_W),
    .TYPE_CODE (TYPE_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy_i    (busy_i),
    .sel_i     (sel_i),
    .rx_word   (rx_word),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .stop_stb  (stop_stb)
);

// File: tb/twsl_slave_tb.sv
module twsl_slave_tb;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [2:0] sel;
    logic       busy;
    logic [7:0] rx_data;
    logic       wr_stb, rd_stb, stop_stb;
    logic [7:0] tx_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    int         wr_total = 0;
    int         rd_total = 0;
    int         stop_total = 0;
    logic [7:0] wr_log [0:63];
    logic [7:0] base_ptr = 8'h00;
    int         base_cnt = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] tx_pat(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    function automatic logic [7:0] addr_byte(input logic [3:0] tc, input logic [2:0] s,
                                             input logic rd);
        return {tc, s, rd};
    endfunction

    always_comb tx_data = tx_pat(base_ptr + 8'(rd_total - base_cnt));

    always @(posedge clk) begin
        if (wr_stb) begin
            wr_log[wr_total[5:0]] <= rx_data;
            wr_total <= wr_total + 1;
        end
        if (rd_stb) rd_total <= rd_total + 1;
        if (stop_stb) stop_total <= stop_total + 1;
    end

    twsl_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .sel_i    (sel),
        .busy_i   (busy),
        .rx_data  (rx_data),
        .wr_stb   (wr_stb),
        .tx_data  (tx_data),
        .rd_stb   (rd_stb),
        .stop_stb (stop_stb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b1; hold(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold(HALF);
            scl_m = 1'b1; hold(HALF);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hold(HALF);
        ack = ~sda_bus;
        scl_m = 1'b1; hold(HALF);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(HALF);
            b[i] = sda_bus;
            scl_m = 1'b1; hold(HALF);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        scl_m = 1'b0;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        base_ptr = p;
        base_cnt = rd_total;
    endtask

    initial begin
        logic       ack;
        logic [7:0] got;
        logic [7:0] exp_b [0:3];
        int         w0, r0, s0;

        rst_n = 1'b0;
        sel   = 3'b101;
        busy  = 1'b0;
        hold(10);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset strobes", {wr_stb, rd_stb, stop_stb}, 0);
        rst_n = 1'b1;
        hold(10);

        // R1: byte clocked without a START is not acknowledged
        scl_m = 1'b0; hold(HALF);
        send_byte(addr_byte(4'b1010, sel, 1'b0), ack);
        chk("R1 no start no ack", ack, 0);
        bus_stop();
        chk("R8 idle stop no pulse", stop_total, 0);

        // R2 R4 R8: two-byte write
        w0 = wr_total; s0 = stop_total;
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b0), ack);
        chk("R2 address ack", ack, 1);
        send_byte(8'hC3, ack);
        chk("R4 data ack 0", ack, 1);
        send_byte(8'h5A, ack);
        chk("R4 data ack 1", ack, 1);
        bus_stop();
        hold(4);
        chk("R4 write count", wr_total - w0, 2);
        chk("R4 byte 0", wr_log[w0[5:0]], 8'hC3);
        chk("R4 byte 1", wr_log[(w0 + 1) & 63], 8'h5A);
        chk("R8 stop pulse", stop_total - s0, 1);

        // R5 R6: sequential read then NACK
        set_ptr(8'h40);
        r0 = rd_total; s0 = stop_total;
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b1), ack);
        chk("R2 read address ack", ack, 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i != 2, got);
            chk("R5 read data", got, tx_pat(8'h40 + 8'(i)));
        end
        recv_byte(1'b0, got);
        chk("R6 after nack reads ones", got, 8'hFF);
        chk("R6 strobe count", rd_total - r0, 3);
        bus_stop();
        hold(4);
        chk("R8 stop after nack ignored", stop_total - s0, 0);

        // R3: wrong type code, then wrong select
        w0 = wr_total;
        bus_start();
        send_byte(addr_byte(4'b1011, sel, 1'b0), ack);
        chk("R3 type mismatch nack", ack, 0);
        send_byte(8'h77, ack);
        chk("R3 data ignored ack", ack, 0);
        bus_start();
        send_byte(addr_byte(4'b1010, 3'b001, 1'b0), ack);
        chk("R3 select mismatch nack", ack, 0);
        bus_stop();
        chk("R3 no write strobe", wr_total - w0, 0);

        // R7: acknowledge polling
        busy = 1'b1;
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b0), ack);
        chk("R7 busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b1), ack);
        chk("R7 ready ack", ack, 1);
        recv_byte(1'b0, got);
        bus_stop();

        // R9: repeated START in mid byte
        w0 = wr_total;
        set_ptr(8'h10);
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b0), ack);
        send_bits(8'hA5, 3);
        bus_start();
        send_byte(addr_byte(4'b1010, sel, 1'b1), ack);
        chk("R9 restart address ack", ack, 1);
        recv_byte(1'b0, got);
        chk("R9 read after restart", got, tx_pat(8'h10));
        bus_stop();
        chk("R9 partial byte dropped", wr_total - w0, 0);

        // randomized mix
        void'($urandom(32'd20240611));
        for (int it = 0; it < 10; it++) begin
            int n;
            logic rd;
            logic [7:0] p;
            sel = 3'($urandom);
            n   = 1 + int'($urandom % 4);
            rd  = 1'($urandom);
            bus_start();
            send_byte(addr_byte(4'b1010, sel, rd), ack);
            chk("R2 random address ack", ack, 1);
            if (rd) begin
                p = 8'($urandom);
                set_ptr(p);
                for (int k = 0; k < n; k++) begin
                    recv_byte(k != n - 1, got);
                    chk("R5 random read", got, tx_pat(p + 8'(k)));
                end
            end else begin
                w0 = wr_total;
                for (int k = 0; k < n; k++) begin
                    exp_b[k] = 8'($urandom);
                    send_byte(exp_b[k], ack);
                    chk("R4 random write ack", ack, 1);
                end
                hold(4);
                for (int k = 0; k < n; k++)
                    chk("R4 random write data", wr_log[(w0 + k) & 63], exp_b[k]);
            end
            bus_stop();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule